// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservation state one CPU needs for load-linked and store-conditional operations. A load-linked operation stores the physical address it touched and marks the reservation live. A later store-conditional lets its memory write go ahead only while the reservation is still live. In the same cycle it reports that outcome as its success result. Whatever the outcome, the store-conditional then drops the reservation.

The monitor also watches every write that any CPU puts on the shared bus. A write that lands in the reserved 8-byte granule drops the reservation. This is what turns a read, a modify and a conditional write into an atomic sequence without locking the bus. The CPU issues operations on the operation port. The monitor drives the write enable that gates the actual store, and it returns a one-cycle result.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the reservation is clear: a store-conditional issued before any load-linked gets mem_we_o=0 and sc_ok_o=0.
- R2: An operation with op_valid_i=1 and op_kind_i=0 (load-linked) makes the reservation live and records op_addr_i as the reserved address.
- R3: A store-conditional (op_valid_i=1, op_kind_i=1) with a live reservation asserts mem_we_o=1, sc_ok_o=1 and sc_done_o=1 in the same cycle.
- R4: A store-conditional with no live reservation still completes in its own cycle with sc_done_o=1, mem_we_o=0 and sc_ok_o=0.
- R5: Every store-conditional clears the reservation, whether or not its write took place.
- R6: A snooped write (snoop_valid_i=1) whose address matches the reserved address in bits [ADDR_W-1:3] clears the reservation.
- R7: Address bits [2:0] take no part in matching. A snooped write to a different 8-byte granule leaves the reservation unchanged.
- R8: When a load-linked and a snooped write arrive in the same cycle, the load-linked wins and the reservation is live afterwards, even if the snoop hits.
- R9: A snooped write that hits the reservation in the same cycle as a store-conditional makes that store-conditional fail (mem_we_o=0, sc_ok_o=0).
- R10: A new load-linked replaces the reserved address. After it, snooped writes to the previous address have no effect.
- R11: mem_we_o is asserted only during a store-conditional. It stays 0 for idle cycles and for load-linked operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | CPU operation present this cycle |
| op_kind_i | input | 1 | 0 = load-linked, 1 = store-conditional |
| op_addr_i | input | ADDR_W | Physical address of the operation |
| snoop_valid_i | input | 1 | A bus write from any CPU is visible this cycle |
| snoop_addr_i | input | ADDR_W | Physical address of the snooped write |
| mem_we_o | output | 1 | Write enable for the store-conditional's memory write |
| sc_done_o | output | 1 | A store-conditional completes this cycle |
| sc_ok_o | output | 1 | Success result of the store-conditional |

## Verification
The reservation flag and the stored address are visible only through store-conditional results. A flag left live when it should be clear, or cleared when it should be live, shows up as a wrong mem_we_o and sc_ok_o on the next store-conditional. A wrong stored address shows up only after a snooped write tests it, and then on the store-conditional that follows. The bench therefore pairs each load-linked, snoop and priority pattern with a store-conditional within one or two cycles. A reference model compares all three outputs on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LOAD_LINK  = 1'b0,
    OP_STORE_COND = 1'b1
  } llsc_op_e;

  localparam int unsigned DEF_ADDR_W   = 40;
  localparam int unsigned DEF_GRAN_LSB = 3;
endpackage

// File: rtl/llsc_addr_match.sv
module llsc_addr_match #(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned GRAN_LSB = 3
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);
  // Granule compare: low GRAN_LSB bits shifted out
  always_comb eq_o = ((a_i >> GRAN_LSB) == (b_i >> GRAN_LSB));
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ll_i,
  input  logic              sc_i,
  input  logic              snoop_hit_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              flag_q;
  logic [ADDR_W-1:0] addr_q;

  // Priority: load-linked > store-conditional > snoop clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else if (ll_i) begin
      flag_q <= 1'b1;
      addr_q <= ll_addr_i;
    end else if (sc_i || snoop_hit_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;

  a_r2_ll_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_i |=> (flag_q && addr_q == $past(ll_addr_i)));
  a_r5_sc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && !ll_i) |=> !flag_q);
  a_r6_snoop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_i && !ll_i) |=> !flag_q);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ll_i && !sc_i && !snoop_hit_i) |=> ($stable(flag_q) && $stable(addr_q)));
endmodule

// File: rtl/llsc_sc_gate.sv
module llsc_sc_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sc_i,
  input  logic flag_i,
  input  logic snoop_hit_i,
  output logic we_o,
  output logic ok_o,
  output logic done_o
);
  logic pass;

  // A hitting snoop in the same cycle wins over the store
  always_comb begin
    pass   = sc_i && flag_i && !snoop_hit_i;
    we_o   = pass;
    ok_o   = pass;
    done_o = sc_i;
  end

  a_r4_no_flag_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !flag_i) |-> (!we_o && !ok_o));
  a_r9_snoop_kills_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && snoop_hit_i) |-> !we_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned GRAN_LSB = DEF_GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              mem_we_o,
  output logic              sc_done_o,
  output logic              sc_ok_o
);
  logic              is_ll, is_sc;
  logic              flag;
  logic [ADDR_W-1:0] resv_addr;
  logic              addr_eq, snoop_hit;

  always_comb begin
    is_ll = op_valid_i && (llsc_op_e'(op_kind_i) == OP_LOAD_LINK);
    is_sc = op_valid_i && (llsc_op_e'(op_kind_i) == OP_STORE_COND);
  end

  llsc_addr_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_match (
    .a_i  (snoop_addr_i),
    .b_i  (resv_addr),
    .eq_o (addr_eq)
  );

  assign snoop_hit = snoop_valid_i && flag && addr_eq;

  llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ll_i        (is_ll),
    .sc_i        (is_sc),
    .snoop_hit_i (snoop_hit),
    .ll_addr_i   (op_addr_i),
    .flag_o      (flag),
    .addr_o      (resv_addr)
  );

  llsc_sc_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sc_i        (is_sc),
    .flag_i      (flag),
    .snoop_hit_i (snoop_hit),
    .we_o        (mem_we_o),
    .ok_o        (sc_ok_o),
    .done_o      (sc_done_o)
  );

  a_r11_we_only_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (op_valid_i && op_kind_i));
  a_r3_result_matches_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_o |-> (mem_we_o && sc_done_o));
endmodule

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid = 1'b0, op_kind = 1'b0, snoop_valid = 1'b0;
  logic [AW-1:0] op_addr = '0, snoop_addr = '0;
  logic          mem_we, sc_done, sc_ok;

  int  n_cmp = 0, n_bad = 0;
  bit  finished = 1'b0;
  bit            m_flag = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  llsc_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_addr_i(op_addr),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .mem_we_o(mem_we), .sc_done_o(sc_done), .sc_ok_o(sc_ok)
  );

  task automatic cmp(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {we,done,ok} got %b exp %b", tag, got, exp);
    end
  endtask

  // Drive one cycle, compare against the model, then advance the model
  task automatic step(input bit v, input bit k, input logic [AW-1:0] a,
                      input bit sv, input logic [AW-1:0] sa, input string tag);
    bit hit, e_we, e_done;
    @(negedge clk);
    op_valid = v; op_kind = k; op_addr = a; snoop_valid = sv; snoop_addr = sa;
    #1;
    hit    = sv && m_flag && ((sa >> 3) == (m_addr >> 3));
    e_done = v && k;
    e_we   = e_done && m_flag && !hit;
    cmp(tag, {mem_we, sc_done, sc_ok}, {e_we, e_done, e_we});
    @(posedge clk);
    if (v && !k) begin m_flag = 1'b1; m_addr = a; end
    else if ((v && k) || hit) m_flag = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, 0, '0, tag);
  endtask

  localparam logic [AW-1:0] A = 40'h00_0000_1000;
  localparam logic [AW-1:0] B = 40'h00_0000_2000;

  initial begin
    repeat (2) @(negedge clk);
    #1 cmp("R1 in reset", {mem_we, sc_done, sc_ok}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    idle("R11 idle");
    step(1, 1, A, 0, '0, "R1 R4 sc after reset");
    step(1, 0, A, 0, '0, "R2 R11 ll");
    step(1, 1, A, 0, '0, "R3 sc live");
    step(1, 1, A, 0, '0, "R5 sc after sc");
    step(1, 0, A, 0, '0, "R2 ll");
    step(1, 1, A, 0, '0, "R3 sc right after ll");
    step(1, 0, A, 0, '0, "R2 ll");
    step(0, 0, '0, 1, A | 40'h5, "R6 snoop same granule");
    step(1, 1, A, 0, '0, "R6 R7 sc after low-bit snoop");
    step(1, 0, A, 0, '0, "R2 ll");
    step(0, 0, '0, 1, A + 40'h8, "R7 snoop next granule");
    step(0, 0, '0, 1, A - 40'h1, "R7 snoop prev granule");
    step(1, 1, A, 0, '0, "R7 sc survives");
    step(1, 0, A, 1, A, "R8 ll with hit snoop");
    step(1, 1, A, 0, '0, "R8 sc after ll+snoop");
    step(1, 0, A, 0, '0, "R2 ll");
    step(1, 1, A, 1, A | 40'h7, "R9 sc with hit snoop");
    step(1, 1, A, 0, '0, "R9 R5 sc after");
    step(1, 0, A, 0, '0, "R10 ll A");
    step(1, 0, B, 0, '0, "R10 ll B");
    step(0, 0, '0, 1, A, "R10 snoop old");
    step(1, 1, B, 0, '0, "R10 sc B ok");
    step(1, 0, B, 0, '0, "R10 ll B");
    step(0, 0, '0, 1, B | 40'h3, "R10 snoop new");
    step(1, 1, B, 0, '0, "R10 R6 sc fails");
    step(1, 0, A, 0, '0, "R11 ll");
    step(1, 0, A, 0, '0, "R11 ll while live");
    idle("R11 idle live");
    step(1, 1, A, 1, B, "R7 R3 sc with miss snoop");
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] oa, sa;
      oa = A + 40'({$urandom_range(0, 3), 3'b000}) + 40'($urandom_range(0, 7));
      sa = A + 40'({$urandom_range(0, 3), 3'b000}) + 40'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), oa,
           1'($urandom_range(0, 2) == 0), sa, "RAND R2 R5 R6 R8 R9 R11");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule